// File: doc/BRIEF.md
# Programmable Binary Timer Divider

The block is a binary counter of up to sixteen stages that advances once per clock edge on which a count enable is high. Its output follows one of four counter taps, chosen by a two-bit stage select. In recycle mode the block divides the count rate by 2^N and gives a square wave. In single-transition mode it acts as a one-shot timer. After a reset it waits 2^(N-1) counts, then flips its output once and holds the new level.

A polarity input sets the level the output takes after reset. A master reset input clears the count and the latch, and no counting happens while it is high. A power-on input stands in for the power-up event. When the auto-reset disable input is low, power-on simply clears the block and counting starts at once. When that input is high, the block stays frozen after power-on until a master reset pulse has come and gone.

Top module: `bin_timer`

## Requirements
- R1: While `por` is high with `auto_off` low, the count is cleared and `tmr_out` equals `invert`. Counting starts on the first enabled edge after `por` falls.
- R2: The count rises by exactly one on each rising `clk` edge where `cnt_en` is high and no reset or hold is active. On every other edge it keeps its value.
- R3: `stage_sel` picks the tap stage N from parameters: 2'b00 selects `STG_00` (default 13), 2'b01 selects `STG_01` (default 10), 2'b10 selects `STG_10` (default 8) and 2'b11 selects `STG_11` (default 16). The tap is count bit N-1.
- R4: With `recycle` = 1, `tmr_out` equals bit N-1 of the count XOR `invert`. This is a square wave of period 2^N counts.
- R5: With `recycle` = 0, `tmr_out` flips once, on the edge that brings the count since reset to 2^(N-1). It keeps that level through any further counting.
- R6: `invert` = 0 makes the output low after reset, and `invert` = 1 makes it high.
- R7: While `mreset` is high, the count and the latch are cleared and enabled edges do not advance the count. A full new delay is timed after `mreset` falls.
- R8: If `auto_off` is high during `por`, no counting takes place after `por` falls until a master reset pulse has been applied and released.
- R9: While `recycle` is 1, the single-transition latch is held clear. After a return to `recycle` = 0, the output sits at its reset level until the tap next rises.
- R10: A change of `stage_sel` takes effect on the tap at once, without clearing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on event, active high |
| auto_off | input | 1 | 1 = block waits for a master reset after power-on |
| mreset | input | 1 | Master reset, active high |
| cnt_en | input | 1 | Count enable, one count per enabled edge |
| stage_sel | input | 2 | Tap stage select |
| recycle | input | 1 | 1 = square-wave mode, 0 = single transition |
| invert | input | 1 | Output level after reset |
| tmr_out | output | 1 | Timer output |

## Verification
The assertions take `por` as a reset that disables them while it is high. They expect every other input to change only between clock edges, so that each edge sees a stable level of `mreset`, `cnt_en` and `recycle`. The bench drives all inputs on the falling edge and samples the output on the next falling edge. It applies power-on only with `mreset` low, so the hold flag always comes from a single clear source. The bench uses a reduced configuration of eight stages with taps 6, 3, 2 and 8. This keeps the odd order of the select code while letting every tap run through a full period.

// File: rtl/bin_timer.sv
module bin_timer #(
  parameter int W      = 16,
  parameter int STG_00 = 13,
  parameter int STG_01 = 10,
  parameter int STG_10 = 8,
  parameter int STG_11 = 16
) (
  input  logic       clk,
  input  logic       por,
  input  logic       auto_off,
  input  logic       mreset,
  input  logic       cnt_en,
  input  logic [1:0] stage_sel,
  input  logic       recycle,
  input  logic       invert,
  output logic       tmr_out
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] B00 = IW'(STG_00 - 1);
  localparam logic [IW-1:0] B01 = IW'(STG_01 - 1);
  localparam logic [IW-1:0] B10 = IW'(STG_10 - 1);
  localparam logic [IW-1:0] B11 = IW'(STG_11 - 1);

  logic [W-1:0]  cnt;
  logic [W-1:0]  cnt_inc;
  logic [IW-1:0] bit_idx;
  logic          hold;
  logic          latch;
  logic          busy_rst;
  logic          adv;
  logic          tap_now;
  logic          tap_nxt;
  logic          tap_rise;

  assign busy_rst = por | mreset;
  assign adv      = cnt_en & ~hold & ~busy_rst;
  assign cnt_inc  = cnt + W'(1);

  always_comb begin
    case (stage_sel)
      2'b00:   bit_idx = B00;
      2'b01:   bit_idx = B01;
      2'b10:   bit_idx = B10;
      default: bit_idx = B11;
    endcase
  end

  assign tap_now  = cnt[bit_idx];
  assign tap_nxt  = cnt_inc[bit_idx];
  assign tap_rise = adv & ~tap_now & tap_nxt;

  always_ff @(posedge clk) begin
    if (busy_rst)  cnt <= '0;
    else if (adv)  cnt <= cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (por)          hold <= auto_off;
    else if (mreset)  hold <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (busy_rst | recycle) latch <= 1'b0;
    else if (tap_rise)      latch <= 1'b1;
  end

  assign tmr_out = (recycle ? tap_now : latch) ^ invert;
endmodule

// File: rtl/bin_timer_chk.sv
module bin_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         por,
  input logic         mreset,
  input logic         cnt_en,
  input logic         recycle,
  input logic         invert,
  input logic         tmr_out,
  input logic [W-1:0] cnt,
  input logic         hold,
  input logic         latch
);
  // R7
  mreset_clear_chk: assert property (@(posedge clk) disable iff (por)
    mreset |=> (cnt == '0) && (tmr_out == invert));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (por)
    (cnt_en && !hold && !mreset) |=> cnt == $past(cnt) + W'(1));

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (por)
    (!cnt_en && !mreset) |=> $stable(cnt));

  // R5
  latch_keep_chk: assert property (@(posedge clk) disable iff (por)
    (latch && !recycle && !mreset) |=> latch);

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (por)
    (hold && !mreset) |=> $stable(cnt));

  // R9
  latch_clear_chk: assert property (@(posedge clk) disable iff (por)
    recycle |=> !latch);
endmodule

bind bin_timer bin_timer_chk #(.W(W)) u_chk (
  .clk(clk), .por(por), .mreset(mreset), .cnt_en(cnt_en),
  .recycle(recycle), .invert(invert), .tmr_out(tmr_out),
  .cnt(cnt), .hold(hold), .latch(latch)
);

// File: tb/test_bin_timer.sv
`timescale 1ns/1ps
module test_bin_timer;
  logic clk = 1'b0;
  logic por, auto_off, mreset, cnt_en, recycle, invert;
  logic [1:0] stage_sel;
  logic tmr_out;
  int errs = 0;
  int checks = 0;
  int k;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bin_timer #(.W(8), .STG_00(6), .STG_01(3), .STG_10(2), .STG_11(8)) i_bin_timer (
    .clk(clk), .por(por), .auto_off(auto_off), .mreset(mreset), .cnt_en(cnt_en),
    .stage_sel(stage_sel), .recycle(recycle), .invert(invert), .tmr_out(tmr_out)
  );

  function automatic int stage_of(logic [1:0] s);
    case (s)
      2'b00: return 6;
      2'b01: return 3;
      2'b10: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic bit expect_out(int cnt, int n, bit rec, bit pol);
    if (rec) return bit'((cnt >> (n - 1)) & 1) ^ pol;
    return bit'(cnt >= (1 << (n - 1))) ^ pol;
  endfunction

  task automatic chk(bit exp, string req);
    checks++;
    if (tmr_out !== exp) begin
      errs++;
      $display("FAIL %s: tmr_out=%b expected=%b (count %0d)", req, tmr_out, exp, k);
    end
  endtask

  task automatic tick(bit en);
    cnt_en = en;
    @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
    if (en) k++;
  endtask

  task automatic mpulse(bit en);
    mreset = 1'b1;
    tick(en);
    mreset = 1'b0;
    k = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not end, expected end of stimulus");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    por = 1'b1; auto_off = 1'b0; mreset = 1'b0; cnt_en = 1'b0;
    stage_sel = 2'b10; recycle = 1'b1; invert = 1'b0; k = 0;
    @(negedge clk);
    tick(1'b1);
    tick(1'b0);
    k = 0;
    chk(1'b0, "R1 reset level");
    por = 1'b0;
    tick(1'b1);
    chk(1'b0, "R1 first count");
    tick(1'b1);
    chk(1'b1, "R1 counting after por");

    // R3 R4 R5 R6 R2 sweep
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int r = 0; r < 2; r++) begin
          stage_sel = 2'(s); invert = p[0]; recycle = r[0];
          mpulse(1'b1);
          chk(p[0], "R6 level after reset");
          for (int i = 0; i < (1 << stage_of(2'(s))) + 3; i++) begin
            tick(i % 3 != 2);
            chk(expect_out(k, stage_of(2'(s)), r[0], p[0]),
                r[0] ? "R4 R3 recycle tap" : "R5 R3 single transition");
          end
        end
      end
    end

    // R7 master reset restarts full delay
    stage_sel = 2'b01; invert = 1'b1; recycle = 1'b0;
    mpulse(1'b0);
    for (int i = 0; i < 4; i++) tick(1'b1);
    chk(1'b0, "R5 latched");
    mreset = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(1'b1);
      chk(1'b1, "R7 held in reset");
    end
    mreset = 1'b0; k = 0;
    for (int i = 0; i < 3; i++) begin
      tick(1'b1);
      chk(1'b1, "R7 new delay");
    end
    tick(1'b1);
    chk(1'b0, "R7 new delay expires");

    // R9 recycle clears latch
    recycle = 1'b1;
    tick(1'b0);
    chk(expect_out(k, 3, 1'b1, 1'b1), "R9 recycle follows tap");
    recycle = 1'b0;
    tick(1'b0);
    chk(1'b1, "R9 latch cleared");
    for (int i = 0; i < 8; i++) begin
      tick(1'b1);
      chk((k >= 12) ? 1'b0 : 1'b1, "R9 waits for next tap rise");
    end

    // R10 stage change without reset
    recycle = 1'b1; invert = 1'b0; stage_sel = 2'b10;
    mpulse(1'b0);
    for (int i = 0; i < 3; i++) tick(1'b1);
    chk(1'b1, "R10 tap stage 2");
    stage_sel = 2'b01; tick(1'b0);
    chk(1'b0, "R10 tap stage 3");
    stage_sel = 2'b00; tick(1'b0);
    chk(1'b0, "R10 tap stage 6");
    stage_sel = 2'b10; tick(1'b0);
    chk(1'b1, "R10 back to stage 2");

    // R8 auto reset disabled
    por = 1'b1; auto_off = 1'b1;
    tick(1'b1);
    por = 1'b0; auto_off = 1'b0; k = 0;
    for (int i = 0; i < 10; i++) begin
      tick(1'b1);
      chk(1'b0, "R8 frozen until master reset");
    end
    mpulse(1'b0);
    tick(1'b1);
    tick(1'b1);
    chk(1'b1, "R8 counts after master reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule